// File: doc/BRIEF.md
# Dual-Clock Mailbox Bypass Register

This block carries single control words between two ports that run on separate, free-running clocks. The clocks may be unrelated or may be the same clock. Each direction has one mailbox. The sending port writes a word into its mailbox, and that raises a "mail waiting" flag on the receiving port. The receiver takes the word, which lowers the flag. The sender then sees its "send busy" indication drop and may post the next word. Traffic through the mailboxes never enters the queued data path, so a control word can overtake bulk data that is still waiting in the queue.

Each mailbox keeps its word in a register in the sender's clock domain. Two toggle bits, each passed through a synchronizer, carry the handshake across the clock boundary. The sender flips one toggle when it posts a word. The receiver flips the other when it takes the word. The stored word does not change while the mailbox is occupied, so the receiver can capture it directly at the moment it takes it. Each port has its own synchronous, active-high reset. The two resets are applied together.

Top module: `dual_clock_mailbox`

## Requirements
- R1: While a port's reset is high at a rising edge of its clock, that port's `*_send_busy` and `*_mail_waiting` read 0 and its `*_take_word` reads all zeros from the following cycle on.
- R2: After the sender posts a word on a rising edge of its clock, the receiver's mail flag goes high on the second rising edge of the receiver's clock that falls strictly after that posting edge.
- R3: A put request made while `*_send_busy` is 0 is accepted, and `*_send_busy` reads 1 from the next sender cycle. While no word is accepted, `*_send_busy` never goes from 0 to 1.
- R4: A put request made while `*_send_busy` is 1 is ignored. The word the receiver later takes is the word that was accepted earlier, not the one in the ignored request.
- R5: A take request made while the mail flag is 1 puts the posted word on `*_take_word` from the next receiver cycle and clears the mail flag in that same cycle.
- R6: A take request made while the mail flag is 0 has no effect, and `*_take_word` keeps its value.
- R7: `*_send_busy` returns to 0 on the second rising edge of the sender's clock that falls strictly after the take edge. A new word is accepted from then on.
- R8: The port-A-to-port-B mailbox and the port-B-to-port-A mailbox behave identically and independently of each other.
- R9: R2 to R7 hold when both ports share one clock, when port B runs at 7/3 of port A's frequency, and when port B runs at 3/7 of port A's frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock, free-running |
| rst_a | input | 1 | Port A synchronous reset, active high |
| a_put_en | input | 1 | Port A requests to post a word toward port B |
| a_put_word | input | 36 | Word posted by port A |
| a_take_en | input | 1 | Port A requests to take the word from port B |
| a_take_word | output | 36 | Last word that port A took |
| a_mail_waiting | output | 1 | A word from port B is waiting for port A |
| a_send_busy | output | 1 | Port A's outgoing mailbox still holds a word that has not been taken |
| clk_b | input | 1 | Port B clock, free-running |
| rst_b | input | 1 | Port B synchronous reset, active high |
| b_put_en | input | 1 | Port B requests to post a word toward port A |
| b_put_word | input | 36 | Word posted by port B |
| b_take_en | input | 1 | Port B requests to take the word from port A |
| b_take_word | output | 36 | Last word that port B took |
| b_mail_waiting | output | 1 | A word from port A is waiting for port B |
| b_send_busy | output | 1 | Port B's outgoing mailbox still holds a word that has not been taken |

## Verification
The bench drives both ports with random put and take requests, so it hits the corner cases directly. These include puts aimed at an occupied mailbox, which a design with a missing busy gate would let overwrite an unread word and so deliver the wrong data. They also include takes on an empty mailbox, which a faulty design would use to flip the handshake and produce phantom mail. The bench checks the flag latencies to the exact edge. A synchronizer that is one stage short, or a flag that is decoded from the wrong toggle pair, shows up as a busy or mail flag that rises or falls one cycle off. A flag that sticks would block all further traffic. These checks are repeated with coincident clocks and with the port B clock both faster and slower than port A. A design that mishandled coincident edges would sample a toggle in the same step it changes.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;

    localparam int unsigned MBX_WORD_W      = 36;
    localparam int unsigned MBX_SYNC_STAGES = 2;
    localparam int unsigned MBX_DIRS        = 2;

    localparam int unsigned MBX_A_TO_B = 0;
    localparam int unsigned MBX_B_TO_A = 1;

    typedef struct packed {
        logic busy;
        logic mail;
    } mbx_flags_t;

    function automatic logic mbx_next_flip(input logic cur, input logic fire);
        return cur ^ fire;
    endfunction

    function automatic logic mbx_out_of_step(input logic mine, input logic theirs);
        return mine ^ theirs;
    endfunction

endpackage

// File: rtl/mbx_sync.sv
`timescale 1ns/1ps
module mbx_sync #(
    parameter int unsigned STAGES = mbx_pkg::MBX_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int unsigned DEPTH = (STAGES < 2) ? 2 : STAGES;

    logic [DEPTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[DEPTH-2:0], d};
        end
    end

    assign q = chain[DEPTH-1];
endmodule

// File: rtl/mbx_sender.sv
`timescale 1ns/1ps
module mbx_sender #(
    parameter int unsigned WORD_W = mbx_pkg::MBX_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              put_en,
    input  logic [WORD_W-1:0] put_word,
    input  logic              ack_seen,
    output logic              busy,
    output logic              post_flip,
    output logic [WORD_W-1:0] held_word
);
    import mbx_pkg::*;

    logic accept;

    assign busy   = mbx_out_of_step(post_flip, ack_seen);
    assign accept = put_en & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            post_flip <= 1'b0;
            held_word <= '0;
        end else begin
            post_flip <= mbx_next_flip(post_flip, accept);
            if (accept) begin
                held_word <= put_word;
            end
        end
    end
endmodule

// File: rtl/mbx_receiver.sv
`timescale 1ns/1ps
module mbx_receiver #(
    parameter int unsigned WORD_W = mbx_pkg::MBX_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              post_seen,
    input  logic [WORD_W-1:0] src_word,
    input  logic              take_en,
    output logic [WORD_W-1:0] take_word,
    output logic              mail,
    output logic              ack_flip
);
    import mbx_pkg::*;

    logic grab;

    assign mail = mbx_out_of_step(post_seen, ack_flip);
    assign grab = take_en & mail;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_flip  <= 1'b0;
            take_word <= '0;
        end else begin
            ack_flip <= mbx_next_flip(ack_flip, grab);
            if (grab) begin
                take_word <= src_word;
            end
        end
    end
endmodule

// File: rtl/mbx_channel.sv
`timescale 1ns/1ps
module mbx_channel #(
    parameter int unsigned WORD_W      = mbx_pkg::MBX_WORD_W,
    parameter int unsigned SYNC_STAGES = mbx_pkg::MBX_SYNC_STAGES
) (
    input  logic              wclk,
    input  logic              wrst,
    input  logic              put_en,
    input  logic [WORD_W-1:0] put_word,
    output logic              busy,
    input  logic              rclk,
    input  logic              rrst,
    input  logic              take_en,
    output logic [WORD_W-1:0] take_word,
    output logic              mail
);
    logic              post_flip;
    logic              post_seen;
    logic              ack_flip;
    logic              ack_seen;
    logic [WORD_W-1:0] held_word;

    mbx_sender #(.WORD_W(WORD_W)) u_send (
        .clk       (wclk),
        .rst       (wrst),
        .put_en    (put_en),
        .put_word  (put_word),
        .ack_seen  (ack_seen),
        .busy      (busy),
        .post_flip (post_flip),
        .held_word (held_word)
    );

    mbx_sync #(.STAGES(SYNC_STAGES)) u_post_sync (
        .clk (rclk),
        .rst (rrst),
        .d   (post_flip),
        .q   (post_seen)
    );

    mbx_receiver #(.WORD_W(WORD_W)) u_recv (
        .clk       (rclk),
        .rst       (rrst),
        .post_seen (post_seen),
        .src_word  (held_word),
        .take_en   (take_en),
        .take_word (take_word),
        .mail      (mail),
        .ack_flip  (ack_flip)
    );

    mbx_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (wclk),
        .rst (wrst),
        .d   (ack_flip),
        .q   (ack_seen)
    );
endmodule

// File: rtl/dual_clock_mailbox.sv
`timescale 1ns/1ps
module dual_clock_mailbox #(
    parameter int unsigned WORD_W      = mbx_pkg::MBX_WORD_W,
    parameter int unsigned SYNC_STAGES = mbx_pkg::MBX_SYNC_STAGES
) (
    input  logic              clk_a,
    input  logic              rst_a,
    input  logic              a_put_en,
    input  logic [WORD_W-1:0] a_put_word,
    input  logic              a_take_en,
    output logic [WORD_W-1:0] a_take_word,
    output logic              a_mail_waiting,
    output logic              a_send_busy,
    input  logic              clk_b,
    input  logic              rst_b,
    input  logic              b_put_en,
    input  logic [WORD_W-1:0] b_put_word,
    input  logic              b_take_en,
    output logic [WORD_W-1:0] b_take_word,
    output logic              b_mail_waiting,
    output logic              b_send_busy
);
    import mbx_pkg::*;

    localparam int unsigned NDIR = MBX_DIRS;

    logic [NDIR-1:0]   wclk_v, rclk_v, wrst_v, rrst_v, put_v, take_v;
    logic [WORD_W-1:0] put_word_v  [NDIR];
    logic [WORD_W-1:0] take_word_v [NDIR];
    mbx_flags_t        flags_v     [NDIR];

    assign wclk_v[MBX_A_TO_B] = clk_a;
    assign rclk_v[MBX_A_TO_B] = clk_b;
    assign wrst_v[MBX_A_TO_B] = rst_a;
    assign rrst_v[MBX_A_TO_B] = rst_b;
    assign put_v[MBX_A_TO_B]  = a_put_en;
    assign take_v[MBX_A_TO_B] = b_take_en;
    assign put_word_v[MBX_A_TO_B] = a_put_word;

    assign wclk_v[MBX_B_TO_A] = clk_b;
    assign rclk_v[MBX_B_TO_A] = clk_a;
    assign wrst_v[MBX_B_TO_A] = rst_b;
    assign rrst_v[MBX_B_TO_A] = rst_a;
    assign put_v[MBX_B_TO_A]  = b_put_en;
    assign take_v[MBX_B_TO_A] = a_take_en;
    assign put_word_v[MBX_B_TO_A] = b_put_word;

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        mbx_channel #(
            .WORD_W      (WORD_W),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_chan (
            .wclk      (wclk_v[d]),
            .wrst      (wrst_v[d]),
            .put_en    (put_v[d]),
            .put_word  (put_word_v[d]),
            .busy      (flags_v[d].busy),
            .rclk      (rclk_v[d]),
            .rrst      (rrst_v[d]),
            .take_en   (take_v[d]),
            .take_word (take_word_v[d]),
            .mail      (flags_v[d].mail)
        );
    end

    assign a_send_busy    = flags_v[MBX_A_TO_B].busy;
    assign b_mail_waiting = flags_v[MBX_A_TO_B].mail;
    assign b_take_word    = take_word_v[MBX_A_TO_B];
    assign b_send_busy    = flags_v[MBX_B_TO_A].busy;
    assign a_mail_waiting = flags_v[MBX_B_TO_A].mail;
    assign a_take_word    = take_word_v[MBX_B_TO_A];
endmodule

// File: rtl/mbx_dir_checker.sv
`timescale 1ns/1ps
module mbx_dir_checker #(
    parameter int unsigned WORD_W = mbx_pkg::MBX_WORD_W
) (
    input logic              wclk,
    input logic              wrst,
    input logic              put_en,
    input logic              busy,
    input logic              rclk,
    input logic              rrst,
    input logic              take_en,
    input logic              mail,
    input logic [WORD_W-1:0] take_word
);
    assert_reset_idle_sender_R1: assert property (@(posedge wclk)
        wrst |=> !busy);

    assert_reset_idle_receiver_R1: assert property (@(posedge rclk)
        rrst |=> (!mail && take_word == '0));

    assert_busy_after_put_R3: assert property (@(posedge wclk) disable iff (wrst)
        (put_en && !busy) |=> busy);

    assert_no_spurious_busy_R3: assert property (@(posedge wclk) disable iff (wrst)
        (!put_en && !busy) |=> !busy);

    assert_take_clears_mail_R5: assert property (@(posedge rclk) disable iff (rrst)
        (take_en && mail) |=> !mail);

    assert_idle_take_holds_R6: assert property (@(posedge rclk) disable iff (rrst)
        !(take_en && mail) |=> $stable(take_word));
endmodule

bind dual_clock_mailbox mbx_dir_checker #(.WORD_W(WORD_W)) chk_a_to_b (
    .wclk      (clk_a),
    .wrst      (rst_a),
    .put_en    (a_put_en),
    .busy      (a_send_busy),
    .rclk      (clk_b),
    .rrst      (rst_b),
    .take_en   (b_take_en),
    .mail      (b_mail_waiting),
    .take_word (b_take_word)
);

bind dual_clock_mailbox mbx_dir_checker #(.WORD_W(WORD_W)) chk_b_to_a (
    .wclk      (clk_b),
    .wrst      (rst_b),
    .put_en    (b_put_en),
    .busy      (b_send_busy),
    .rclk      (clk_a),
    .rrst      (rst_a),
    .take_en   (a_take_en),
    .mail      (a_mail_waiting),
    .take_word (a_take_word)
);

// File: tb/dual_clock_mailbox_tb_top.sv
`timescale 1ns/1ps
module mailbox_ref_model (
    input  logic        wclk,
    input  logic        wrst,
    input  logic        put_en,
    input  logic [35:0] put_word,
    input  logic        rclk,
    input  logic        rrst,
    input  logic        take_en,
    output bit          exp_busy,
    output bit          exp_mail,
    output logic [35:0] exp_take,
    output int          delivered,
    output int          ignored_puts
);
    bit          posted;
    bit          consumed;
    int          wr_age;
    int          rd_age;
    logic [35:0] held[$];

    initial begin
        posted = 0; consumed = 0; wr_age = 0; rd_age = 0;
        exp_take = '0; delivered = 0; ignored_puts = 0;
    end

    // sender view: busy from the accepting edge until two sender edges after the take
    always @(posedge wclk) begin
        if (wrst) begin
            posted   <= 0;
            consumed <= 0;
            wr_age   <= 0;
            held.delete();
        end else if (consumed) begin
            if (put_en) ignored_puts <= ignored_puts + 1;
            if (wr_age == 1) begin
                posted   <= 0;
                consumed <= 0;
                wr_age   <= 0;
            end else begin
                wr_age <= wr_age + 1;
            end
        end else if (put_en && !posted) begin
            posted <= 1;
            held.push_back(put_word);
        end else if (put_en) begin
            ignored_puts <= ignored_puts + 1;
        end
    end

    // receiver view: mail visible two receiver edges after the posting edge
    always @(posedge rclk) begin
        if (rrst) begin
            rd_age   <= 0;
            consumed <= 0;
            exp_take <= '0;
        end else if (posted && !consumed) begin
            if (rd_age >= 2 && take_en) begin
                consumed  <= 1;
                rd_age    <= 0;
                exp_take  <= held.pop_front();
                delivered <= delivered + 1;
            end else if (rd_age < 2) begin
                rd_age <= rd_age + 1;
            end
        end
    end

    assign exp_busy = posted;
    assign exp_mail = posted && !consumed && (rd_age >= 2);
endmodule

module dual_clock_mailbox_tb_top;
    bit          clk_a = 0;
    bit          clk_b_free = 0;
    bit          coincident = 1;
    realtime     b_half = 10.0;
    logic        clk_b;
    logic        rst_a = 1, rst_b = 1;
    logic        a_put_en = 0, a_take_en = 0, b_put_en = 0, b_take_en = 0;
    logic [35:0] a_put_word = '0, b_put_word = '0;
    logic [35:0] a_take_word, b_take_word;
    logic        a_mail_waiting, a_send_busy, b_mail_waiting, b_send_busy;

    bit   checks_on = 0;
    bit   traffic_on = 0;
    bit   finished = 0;
    int   n_checks = 0;
    int   n_fails = 0;

    bit          ab_busy, ab_mail, ba_busy, ba_mail;
    logic [35:0] ab_take, ba_take;
    int          ab_deliv, ab_ign, ba_deliv, ba_ign;

    always #10.0 clk_a = ~clk_a;
    initial begin
        #0.501;
        forever begin
            #(b_half) clk_b_free = ~clk_b_free;
        end
    end
    assign clk_b = coincident ? clk_a : clk_b_free;

    dual_clock_mailbox dut_i (
        .clk_a(clk_a), .rst_a(rst_a),
        .a_put_en(a_put_en), .a_put_word(a_put_word),
        .a_take_en(a_take_en), .a_take_word(a_take_word),
        .a_mail_waiting(a_mail_waiting), .a_send_busy(a_send_busy),
        .clk_b(clk_b), .rst_b(rst_b),
        .b_put_en(b_put_en), .b_put_word(b_put_word),
        .b_take_en(b_take_en), .b_take_word(b_take_word),
        .b_mail_waiting(b_mail_waiting), .b_send_busy(b_send_busy)
    );

    mailbox_ref_model ref_ab (
        .wclk(clk_a), .wrst(rst_a), .put_en(a_put_en), .put_word(a_put_word),
        .rclk(clk_b), .rrst(rst_b), .take_en(b_take_en),
        .exp_busy(ab_busy), .exp_mail(ab_mail), .exp_take(ab_take),
        .delivered(ab_deliv), .ignored_puts(ab_ign)
    );

    mailbox_ref_model ref_ba (
        .wclk(clk_b), .wrst(rst_b), .put_en(b_put_en), .put_word(b_put_word),
        .rclk(clk_a), .rrst(rst_a), .take_en(a_take_en),
        .exp_busy(ba_busy), .exp_mail(ba_mail), .exp_take(ba_take),
        .delivered(ba_deliv), .ignored_puts(ba_ign)
    );

    task automatic check(input bit ok, input string tag, input logic [35:0] act,
                         input logic [35:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $realtime, act, exp);
        end
    endtask

    // random stimulus, driven away from the active edges
    always @(negedge clk_a) begin
        if (traffic_on) begin
            a_put_en   = ($urandom_range(0, 2) == 0);
            a_put_word = {$urandom_range(0, 15), $urandom};
            a_take_en  = ($urandom_range(0, 1) == 1);
        end else begin
            a_put_en = 0; a_take_en = 0;
        end
    end
    always @(negedge clk_b) begin
        if (traffic_on) begin
            b_put_en   = ($urandom_range(0, 2) == 0);
            b_put_word = {$urandom_range(0, 15), $urandom};
            b_take_en  = ($urandom_range(0, 1) == 1);
        end else begin
            b_put_en = 0; b_take_en = 0;
        end
    end

    // port A side compared with the model every cycle
    always @(negedge clk_a) begin
        if (checks_on) begin
            check(a_send_busy === ab_busy,
                  rst_a ? "R1 a_send_busy" : (ab_busy ? "R3 a_send_busy" : "R7 a_send_busy"),
                  36'(a_send_busy), 36'(ab_busy));
            check(a_mail_waiting === ba_mail,
                  rst_a ? "R1 a_mail_waiting" : (ba_mail ? "R8 R2 a_mail_waiting" : "R8 R5 a_mail_waiting"),
                  36'(a_mail_waiting), 36'(ba_mail));
            check(a_take_word === ba_take,
                  rst_a ? "R1 a_take_word" : "R8 R4 R5 R6 a_take_word",
                  a_take_word, ba_take);
        end
    end

    // port B side compared with the model every cycle
    always @(negedge clk_b) begin
        if (checks_on) begin
            check(b_send_busy === ba_busy,
                  rst_b ? "R1 b_send_busy" : (ba_busy ? "R8 R3 b_send_busy" : "R8 R7 b_send_busy"),
                  36'(b_send_busy), 36'(ba_busy));
            check(b_mail_waiting === ab_mail,
                  rst_b ? "R1 b_mail_waiting" : (ab_mail ? "R2 b_mail_waiting" : "R5 b_mail_waiting"),
                  36'(b_mail_waiting), 36'(ab_mail));
            check(b_take_word === ab_take,
                  rst_b ? "R1 b_take_word" : "R4 R5 R6 b_take_word",
                  b_take_word, ab_take);
        end
    end

    task automatic run_phase(input bit same_clock, input realtime half_b, input string name);
        int d0_ab, d0_ba, i0_ab, i0_ba;
        @(negedge clk_a);
        rst_a = 1;
        rst_b = 1;
        coincident = same_clock;
        b_half = half_b;
        repeat (8) @(negedge clk_a);
        repeat (8) @(negedge clk_b);
        checks_on = 1;
        repeat (3) @(negedge clk_a);
        // R1: reset values held at the ports
        check(a_send_busy === 1'b0 && b_send_busy === 1'b0, "R1 busy under reset",
              {34'd0, a_send_busy, b_send_busy}, 36'd0);
        check(a_mail_waiting === 1'b0 && b_mail_waiting === 1'b0, "R1 mail under reset",
              {34'd0, a_mail_waiting, b_mail_waiting}, 36'd0);
        check(a_take_word === '0 && b_take_word === '0, "R1 take words under reset",
              a_take_word | b_take_word, 36'd0);
        rst_a = 0;
        @(negedge clk_b);
        rst_b = 0;
        d0_ab = ab_deliv; d0_ba = ba_deliv; i0_ab = ab_ign; i0_ba = ba_ign;
        traffic_on = 1;
        repeat (3000) @(negedge clk_a);
        traffic_on = 0;
        repeat (20) @(negedge clk_a);
        repeat (20) @(negedge clk_b);
        // R9: traffic flowed both ways under this clock relation
        check(ab_deliv - d0_ab > 20, {"R9 A-to-B deliveries ", name},
              36'(ab_deliv - d0_ab), 36'd21);
        check(ba_deliv - d0_ba > 20, {"R9 R8 B-to-A deliveries ", name},
              36'(ba_deliv - d0_ba), 36'd21);
        // R4: puts against an occupied mailbox were exercised
        check(ab_ign - i0_ab > 0 && ba_ign - i0_ba > 0, {"R4 ignored puts seen ", name},
              36'(ab_ign - i0_ab + ba_ign - i0_ba), 36'd1);
        checks_on = 0;
    endtask

    initial begin
        run_phase(1'b1, 10.0,   "1:1 coincident");
        run_phase(1'b0, 4.286,  "A:B 3:7");
        run_phase(1'b0, 23.334, "A:B 7:3");
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #4000000.0;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule